// File: doc/BRIEF.md
# Two-Level Rotating-Priority Interrupt Controller

This block gathers 32 interrupt sources, latches them into a pending register and turns them into two processor requests: a fast request (`fiq`) for sources routed to the fast path, and a normal request (`irq`) for the rest. Each source input is qualified as level-sensitive or edge-triggered by a matching configuration pin. Software drives a small 32-bit register port to set routing, masking and priority, and to acknowledge interrupts.

Normal sources that are pending and not masked are resolved by two levels of arbiters. Six first-level arbiters each serve up to six sources. One second-level arbiter chooses among the first-level arbiters that have a request. Each arbiter has a 2-bit selector and a rotate-enable bit. The final winner is captured as a one-hot bit in the in-service register, and its number is captured in the vector-number register. Arbitration then stops until software clears the in-service bit. Register reads are combinational. A write takes effect at the clock edge on which it is presented. The port has no handshake: every access completes in one cycle, so no back-pressure exists.

Top module: `irq_tree_ctrl`

## Requirements
- R1: Register addresses on `reg_addr` are: 0 source-pending, 1 fast-route, 2 mask, 3 priority, 4 in-service, 5 vector-number. After reset these read as 0, 0, 0xFFFFFFFF, 0x0000007F, 0 and 0, and `fiq` and `irq` are low.
- R2: A write to source-pending or in-service clears every bit written as 1 and leaves all other bits unchanged. A level source that is still high keeps its source-pending bit set through such a clear. A new source event in the same cycle as a clear of that bit also leaves the bit set.
- R3: A write to fast-route stores the data with bits 24 and 6 forced to 0. A write to mask stores the data with bits 24 and 6 forced to 1.
- R4: Only priority bits 20:0 are writable. Bit n is the rotate-enable of arbiter n, and bits 8+2n:7+2n hold the selector of arbiter n, for n = 0..6. Arbiter 6 is the second-level arbiter.
- R5: `fiq` is high while any source-pending bit also has its fast-route bit set, whatever the mask holds. While `fiq` is high, no normal arbitration commits.
- R6: While in-service is nonzero, `irq` is high, and neither in-service nor vector-number changes except through software clears.
- R7: First-level arbiter 0 serves sources 0–3 on slots 1–4. For arbiters a = 1..4, slot s serves source 6a+s-2, except that sources 6 and 24 are served by no slot. Arbiter 5 serves sources 28–31 on slots 1–4. The second-level arbiter's slot a requests when arbiter a has a request. With selector v, an arbiter scans slot 0 first, then slots v+1, v+2, … cycling through 1–4, and slot 5 last.
- R8: When `fiq` is low, in-service is zero and a winner exists, the next clock edge loads the winner's number into vector-number and sets only its in-service bit. `irq` follows from in-service.
- R9: An edge-qualified source sets its pending bit only on a 0-to-1 transition. A level source sets its pending bit on every cycle it is high.
- R10: On a commit, only the winning first-level arbiter and the second-level arbiter may advance their selectors, each by one modulo 4, and only if its rotate-enable bit is set.
- R11: A priority read returns the current selectors, including any advances made by arbitration, together with the rotate-enable bits.
- R12: Reads from addresses 6 and 7 return 0xFFFFFFFF. Writes to vector-number have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 32 | Interrupt source lines |
| src_is_level | input | 32 | 1 = level-qualified source, 0 = edge-qualified |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| fiq | output | 1 | Fast interrupt request |
| irq | output | 1 | Normal interrupt request |

## Verification
Two events can land in the same cycle: a new event on a source, and a software write that clears that source's pending bit. The bench provokes this by raising a source line on the same edge that carries the clear. It then reads source-pending back, and the bit must be set. A second interaction involves the fast path and normal arbitration. A fast source and an unmasked normal source are made pending together, and in-service must stay at zero until the fast source is cleared. After that, the normal source must commit with the correct vector number.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC   = 32;
  localparam int DW     = 32;
  localparam int AW     = 3;
  localparam int NARB   = 6;
  localparam int SLOTS  = 6;
  localparam int NLVL   = NARB + 1;
  localparam int SELW   = 2;
  localparam int IDW    = $clog2(NSRC);
  localparam int SLW    = $clog2(SLOTS);
  localparam int PRIO_W = NLVL + NLVL * SELW;
  localparam logic [DW-1:0] RSV_BITS = 32'h0100_0040;

  typedef enum logic [AW-1:0] {
    A_SRCPND = 3'd0,
    A_ROUTE  = 3'd1,
    A_MASK   = 3'd2,
    A_PRIO   = 3'd3,
    A_INSVC  = 3'd4,
    A_VECNUM = 3'd5
  } reg_addr_e;

  // Source served by first-level arbiter a on slot s, or -1 for an empty slot.
  function automatic int slot_src(int a, int s);
    int v;
    if ((a == 0 || a == NARB - 1) && (s == 0 || s == SLOTS - 1)) return -1;
    if (a == 0) return s - 1;
    if (a == NARB - 1) return 27 + s;
    v = 6 * a + s - 2;
    if (v == 6 || v == 24) return -1;
    return v;
  endfunction
endpackage

// File: rtl/irq_src_qual.sv
module irq_src_qual #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_in,
  input  logic [N-1:0] src_is_level,
  output logic [N-1:0] set_vec
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src_in;
  end

  assign set_vec = (src_is_level & src_in) | (~src_is_level & src_in & ~prev_q);
endmodule

// File: rtl/irq_arb6.sv
module irq_arb6 #(
  parameter int SLOTS = 6,
  parameter int SELW  = 2,
  localparam int SLW  = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] req,
  input  logic [SELW-1:0]  sel,
  output logic             valid,
  output logic [SLW-1:0]   slot
);
  localparam int NROT = SLOTS - 2;

  always_comb begin
    valid = 1'b0;
    slot  = '0;
    for (int k = 0; k < SLOTS; k++) begin
      int pos;
      if (k == 0)              pos = 0;
      else if (k == SLOTS - 1) pos = SLOTS - 1;
      else                     pos = ((k - 1 + int'(sel)) % NROT) + 1;
      if (!valid && req[pos]) begin
        valid = 1'b1;
        slot  = SLW'(pos);
      end
    end
  end
endmodule

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl
  import irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   src_in,
  input  logic [31:0]   src_is_level,
  input  logic          reg_wr_en,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          fiq,
  output logic          irq
);
  logic [NSRC-1:0] srcpnd, route_r, mask_r, insvc, set_vec, service;
  logic [IDW-1:0]  vecnum_r;
  logic [NLVL-1:0] rot_en;
  logic [SELW-1:0] sel_q [NLVL];
  logic [SLOTS-1:0] l1_req [NARB];
  logic [NARB-1:0]  l1_valid;
  logic [SLW-1:0]   l1_slot [NARB];
  logic [IDW-1:0]   src_tab [NARB][SLOTS];
  logic [IDW-1:0]   l1_src [NARB];
  logic             top_valid, fiq_req, commit;
  logic [SLW-1:0]   top_slot;
  logic [IDW-1:0]   win_src;
  logic             wr_src, wr_route, wr_mask, wr_prio, wr_insvc;
  logic [DW-1:0]    prio_rd;

  irq_src_qual #(.N(NSRC)) u_qual (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .src_is_level(src_is_level), .set_vec(set_vec)
  );

  assign service = srcpnd & ~mask_r;
  assign fiq_req = |(srcpnd & route_r);

  for (genvar a = 0; a < NARB; a++) begin : g_l1
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam int SN = slot_src(a, s);
      if (SN >= 0) begin : g_used
        assign l1_req[a][s]  = service[SN];
        assign src_tab[a][s] = IDW'(SN);
      end else begin : g_hole
        assign l1_req[a][s]  = 1'b0;
        assign src_tab[a][s] = '0;
      end
    end
    irq_arb6 #(.SLOTS(SLOTS), .SELW(SELW)) u_arb (
      .req(l1_req[a]), .sel(sel_q[a]), .valid(l1_valid[a]), .slot(l1_slot[a])
    );
    assign l1_src[a] = src_tab[a][l1_slot[a]];
  end

  irq_arb6 #(.SLOTS(NARB), .SELW(SELW)) u_top (
    .req(l1_valid), .sel(sel_q[NLVL-1]), .valid(top_valid), .slot(top_slot)
  );

  assign win_src = l1_src[top_slot];
  assign commit  = !fiq_req && (insvc == '0) && top_valid;

  assign wr_src   = reg_wr_en && reg_addr == A_SRCPND;
  assign wr_route = reg_wr_en && reg_addr == A_ROUTE;
  assign wr_mask  = reg_wr_en && reg_addr == A_MASK;
  assign wr_prio  = reg_wr_en && reg_addr == A_PRIO;
  assign wr_insvc = reg_wr_en && reg_addr == A_INSVC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srcpnd   <= '0;
      route_r  <= '0;
      mask_r   <= '1;
      insvc    <= '0;
      vecnum_r <= '0;
      rot_en   <= '1;
      for (int n = 0; n < NLVL; n++) sel_q[n] <= '0;
    end else begin
      srcpnd <= (srcpnd & ~(wr_src ? reg_wdata : '0)) | set_vec;
      if (wr_route) route_r <= reg_wdata & ~RSV_BITS;
      if (wr_mask)  mask_r  <= reg_wdata | RSV_BITS;
      if (wr_prio) begin
        rot_en <= reg_wdata[NLVL-1:0];
        for (int n = 0; n < NLVL; n++) sel_q[n] <= reg_wdata[NLVL + SELW*n +: SELW];
      end else if (commit) begin
        if (rot_en[top_slot]) sel_q[top_slot] <= sel_q[top_slot] + 1'b1;
        if (rot_en[NLVL-1])   sel_q[NLVL-1]   <= sel_q[NLVL-1] + 1'b1;
      end
      if (commit) begin
        insvc    <= NSRC'(1) << win_src;
        vecnum_r <= win_src;
      end else if (wr_insvc) begin
        insvc <= insvc & ~reg_wdata;
      end
    end
  end

  always_comb begin
    prio_rd = '0;
    prio_rd[NLVL-1:0] = rot_en;
    for (int n = 0; n < NLVL; n++) prio_rd[NLVL + SELW*n +: SELW] = sel_q[n];
  end

  always_comb begin
    case (reg_addr)
      A_SRCPND: reg_rdata = srcpnd;
      A_ROUTE:  reg_rdata = route_r;
      A_MASK:   reg_rdata = mask_r;
      A_PRIO:   reg_rdata = prio_rd;
      A_INSVC:  reg_rdata = insvc;
      A_VECNUM: reg_rdata = DW'(vecnum_r);
      default:  reg_rdata = '1;
    endcase
  end

  assign fiq = fiq_req;
  assign irq = |insvc;
endmodule

// File: rtl/irq_tree_ctrl_chk.sv
module irq_tree_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fiq,
  input logic        irq,
  input logic [31:0] insvc,
  input logic [4:0]  vecnum,
  input logic [31:0] route_q,
  input logic [31:0] mask_q,
  input logic        wr_insvc
);
  a_r3_reserved_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (!route_q[24] && !route_q[6] && mask_q[24] && mask_q[6]));

  a_r5_fast_blocks_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq && insvc == 32'd0) |=> (insvc == 32'd0));

  a_r6_hold_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    (insvc != 32'd0 && !wr_insvc) |=> ($stable(insvc) && $stable(vecnum)));

  a_r8_single_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(insvc));

  a_r8_vector_matches: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (insvc == (32'd1 << vecnum)));
endmodule

bind irq_tree_ctrl irq_tree_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fiq(fiq), .irq(irq), .insvc(insvc),
  .vecnum(vecnum_r), .route_q(route_r), .mask_q(mask_r), .wr_insvc(wr_insvc)
);

// File: tb/irq_tree_ctrl_test.sv
module irq_tree_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RSV = 32'h0100_0040;

  logic clk = 0, rst_n = 0;
  logic [31:0] src_in = '0, src_is_level = '0, reg_wdata = '0, reg_rdata;
  logic reg_wr_en = 0;
  logic [2:0] reg_addr = '0;
  logic fiq, irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  int m_sel [7];
  bit m_rot [7];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_tree_ctrl uut (.*);

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(logic [31:0] m);
    @(negedge clk); src_in = src_in | m;
    @(negedge clk); src_in = src_in & ~m;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int map_src(int a, int s);
    if (a == 0) return (s >= 1 && s <= 4) ? s - 1 : -1;
    if (a == 5) return (s >= 1 && s <= 4) ? 27 + s : -1;
    if (6*a + s - 2 == 6 || 6*a + s - 2 == 24) return -1;
    return 6*a + s - 2;
  endfunction

  function automatic int ord(int sel, int k);
    if (k == 0) return 0;
    if (k == 5) return 5;
    return ((k - 1 + sel) % 4) + 1;
  endfunction

  task automatic load_prio(logic [31:0] p);
    for (int n = 0; n < 7; n++) begin
      m_rot[n] = p[n];
      m_sel[n] = int'(p[7 + 2*n +: 2]);
    end
  endtask

  // Bench model of the two-level resolution with selector rotation.
  task automatic model_pick(logic [31:0] svc, output int win);
    int l1s [6];
    bit l1v [6];
    int top;
    win = -1; top = -1;
    for (int a = 0; a < 6; a++) begin
      l1v[a] = 0; l1s[a] = -1;
      for (int k = 0; k < 6; k++) begin
        int sn;
        sn = map_src(a, ord(m_sel[a], k));
        if (!l1v[a] && sn >= 0 && svc[sn]) begin l1v[a] = 1; l1s[a] = sn; end
      end
    end
    for (int k = 0; k < 6; k++)
      if (top < 0 && l1v[ord(m_sel[6], k)]) top = ord(m_sel[6], k);
    if (top >= 0) begin
      win = l1s[top];
      if (m_rot[top]) m_sel[top] = (m_sel[top] + 1) % 4;
      if (m_rot[6])   m_sel[6]   = (m_sel[6] + 1) % 4;
    end
  endtask

  task automatic run_pattern(logic [31:0] prio, logic [31:0] pat);
    logic [31:0] pend, v, expp;
    int w;
    wr(3'd3, prio); load_prio(prio & 32'h001F_FFFF);
    wr(3'd2, 32'h0);
    pulse(pat);
    pend = pat & ~RSV;
    while (pend != 0) begin
      idle(2);
      model_pick(pend, w);
      rd(3'd5, v); chk(v == w, "R7 winner vector", v, w);
      rd(3'd4, v); chk(v == (32'd1 << w), "R8 in-service one-hot", v, 32'd1 << w);
      chk(irq == 1, "R8 irq", {31'd0, irq}, 1);
      pend[w] = 0;
      wr(3'd0, 32'd1 << w);
      wr(3'd4, 32'd1 << w);
    end
    idle(2);
    expp = '0;
    for (int n = 0; n < 7; n++) begin
      expp[n] = m_rot[n];
      expp[7 + 2*n +: 2] = 2'(m_sel[n]);
    end
    rd(3'd3, v); chk(v == expp, "R10 R11 live selectors", v, expp);
    chk(irq == 0, "R2 irq clear after drain", {31'd0, irq}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3); rst_n = 1; idle(1);

    // R1 reset state
    rd(3'd0, v); chk(v == 0, "R1 source-pending", v, 0);
    rd(3'd1, v); chk(v == 0, "R1 fast-route", v, 0);
    rd(3'd2, v); chk(v == 32'hFFFF_FFFF, "R1 mask", v, 32'hFFFF_FFFF);
    rd(3'd3, v); chk(v == 32'h7F, "R1 priority", v, 32'h7F);
    rd(3'd4, v); chk(v == 0, "R1 in-service", v, 0);
    rd(3'd5, v); chk(v == 0, "R1 vector-number", v, 0);
    chk(!fiq && !irq, "R1 outputs low", {30'd0, fiq, irq}, 0);

    // R3 forced bits, R4 writable width, R12
    wr(3'd2, 32'h0); rd(3'd2, v); chk(v == RSV, "R3 mask forced ones", v, RSV);
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, v); chk(v == ~RSV, "R3 route forced zeros", v, ~RSV);
    wr(3'd1, 32'h0); wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, v); chk(v == 32'h001F_FFFF, "R4 priority width", v, 32'h001F_FFFF);
    wr(3'd3, 32'h7F);
    rd(3'd6, v); chk(v == 32'hFFFF_FFFF, "R12 unmapped read", v, 32'hFFFF_FFFF);
    wr(3'd5, 32'h1F); rd(3'd5, v); chk(v == 0, "R12 vector-number read-only", v, 0);

    // R7 R8 sweep of every served source alone
    for (int i = 0; i < 32; i++) begin
      if (i == 6 || i == 24) continue;
      wr(3'd2, ~(32'd1 << i));
      pulse(32'd1 << i); idle(2);
      rd(3'd5, v); chk(v == i, "R7 R8 single-source vector", v, i);
      rd(3'd4, v); chk(v == (32'd1 << i), "R8 single-source in-service", v, 32'd1 << i);
      wr(3'd0, 32'd1 << i); wr(3'd4, 32'd1 << i); idle(1);
      chk(irq == 0, "R2 in-service clear drops irq", {31'd0, irq}, 0);
    end
    wr(3'd2, 32'hFFFF_FFFF);

    // R2 R9 level versus edge qualification
    src_is_level = 32'h8; src_in = 32'h28; idle(2);
    wr(3'd0, 32'h28); idle(1);
    rd(3'd0, v); chk(v == 32'h8, "R2 R9 level re-sets, held edge does not", v, 32'h8);
    src_in = 0; wr(3'd0, 32'h8);
    rd(3'd0, v); chk(v == 0, "R9 level released clears", v, 0);
    src_is_level = 0;

    // R2 coincident source event and clear
    pulse(32'h1000); idle(1);
    @(negedge clk); src_in = 32'h1000; reg_wr_en = 1; reg_addr = 3'd0; reg_wdata = 32'h1000;
    @(negedge clk); reg_wr_en = 0; src_in = 0;
    rd(3'd0, v); chk(v == 32'h1000, "R2 event beats clear", v, 32'h1000);
    wr(3'd0, 32'h1000);

    // R5 fast path blocks arbitration, ignores mask
    wr(3'd1, 32'h400); wr(3'd2, ~32'h800);
    pulse(32'hC00); idle(3);
    chk(fiq == 1, "R5 fiq asserted with masked fast source", {31'd0, fiq}, 1);
    rd(3'd4, v); chk(v == 0, "R5 no commit during fiq", v, 0);
    wr(3'd0, 32'h400); idle(2);
    chk(fiq == 0, "R5 fiq drops", {31'd0, fiq}, 0);
    rd(3'd5, v); chk(v == 11, "R5 normal commits after fiq", v, 11);
    wr(3'd0, 32'h800); wr(3'd4, 32'h800); wr(3'd1, 0);

    // R6 in-service blocks new arbitration
    wr(3'd3, 32'h7F); wr(3'd2, 0);
    pulse(32'h4); idle(2);
    pulse(32'h200); idle(3);
    rd(3'd5, v); chk(v == 2, "R6 vector held", v, 2);
    rd(3'd4, v); chk(v == 32'h4, "R6 in-service held", v, 32'h4);
    wr(3'd0, 32'h204); wr(3'd4, 32'h4); idle(2);
    wr(3'd2, 32'hFFFF_FFFF);

    // R7 R10 R11 multi-source patterns under several priority settings
    run_pattern(32'h7F, 32'hFFFF_FFFF);
    run_pattern(32'h0000_0000, 32'h0000_0F0F);
    run_pattern(32'h0015_2D00 | 32'h2A, 32'hF000_0003);
    run_pattern(32'h000A_B355, 32'h0AA0_5500);
    run_pattern(32'h0000_007F, 32'h3C3C_3C3C);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule